// File: doc/BRIEF.md
# Bit-Serial SIMD Processing Array

A rectangular grid of identical one-bit processing elements that all obey the same control word on every clock. Each element owns a few single-bit registers and a small bit-addressable memory. Multi-bit words live in memory as a stack of bit-planes, one bit per element per address. Arithmetic on such words runs one bit-plane per cycle, least significant bit first. Elements copy their logic register to their four mesh neighbours, apply any two-input boolean function, and take full-adder steps with a carry kept between cycles. A per-element mask bit lets a data-dependent subset of elements take part in an operation while the others keep their state.

A separate shift plane carries image data sideways through the array. New columns enter at the west edge and finished columns leave at the east edge. This shifting runs in the same cycles as element computation. The whole shift plane can be swapped with one memory bit-plane in one cycle. A single output gives the OR of the logic register across all elements, so an outside sequencer can test whether any element is set.

The control word holds an operation code, a memory address, a boolean truth table, a mask-enable flag and a shift request. Each operation is a named step: NOP, LDP, LDA, LDG, ROUTE_N, ROUTE_S, ROUTE_E, ROUTE_W, BOOL, ADD, CLRC, STP, STB and SXCH. Every operation takes effect on the next rising clock edge, in all elements at once.

Top module: `bitserial_array`

## Requirements
- R1: While reset is low, registers P, A, B, C, G and S of every element are held at 0, so any_p_o and s_out_o read 0.
- R2: op_i codes are NOP=0, LDP=1, LDA=2, LDG=3, ROUTE_N=4, ROUTE_S=5, ROUTE_E=6, ROUTE_W=7, BOOL=8, ADD=9, CLRC=10, STP=11, STB=12 and SXCH=13. Codes 14 and 15 act as NOP. Every operation updates all elements on one rising edge.
- R3: ROUTE_N loads each P from the element one row below, ROUTE_S from one row above, ROUTE_E from one column west and ROUTE_W from one column east. Element (r,c) is at bit r*COLS+c. Vacated border elements receive 0, and there is no wraparound.
- R4: BOOL sets P to fn_i[2*P+M], where M is the element's memory bit at addr_i. Examples: AND=4'b1000, XOR=4'b0110, NOT P=4'b0011, clear=4'b0000.
- R5: ADD sets B to A^P^C and C to the majority of A, P and C. CLRC clears C. Repeating LDA, LDP, ADD and STB over bit-planes from the LSB upward yields the modular sum of two words.
- R6: With mask_en_i high, an element whose G is 0 keeps P, A, B, C and its memory through LDP, LDA, ROUTE_*, BOOL, ADD, CLRC, STP and STB. LDG and SXCH ignore the mask.
- R7: LDP, LDA and LDG copy memory bit addr_i into P, A and G. STP and STB write P and B to memory bit addr_i. Each moves a full bit-plane in one cycle.
- R8: When s_shift_i is high and op_i is not SXCH, S moves one column east. Column 0 takes s_in_i[r], and s_out_o[r] always shows S of column COLS-1 in row r. This happens alongside any other operation.
- R9: SXCH swaps S with memory bit addr_i in every element in one cycle. A shift request in that cycle is ignored.
- R10: any_p_o is the OR of P over all elements, valid in the same cycle as P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Broadcast operation code |
| addr_i | input | ADDR_W | Broadcast memory bit address |
| fn_i | input | 4 | Truth table for BOOL |
| mask_en_i | input | 1 | Gate updates by each element's G |
| s_shift_i | input | 1 | Shift S one column east |
| s_in_i | input | ROWS | West-edge input column of S |
| s_out_o | output | ROWS | East-edge column of S |
| any_p_o | output | 1 | OR of P over the array |

## Verification
Two bit-serial additions run over an 8x8 array, with operand words generated arithmetically per element. One pair gives mixed carry chains. The other pair pushes long carry runs against an all-ones complement pattern, so a wrong carry or sum bit shows up as a word mismatch. Routing is tried in all four directions on the same plane, which separates swapped directions and wrong edge fill. Three truth tables in BOOL separate the roles of P and M in the table index. A masked clear uses the sign plane as G and zeroes only the negative words, which shows the mask gating memory writes. A shift-in run overlapped with eight east routes shows the two planes are independent. Plane readback issues SXCH with a shift request held high, so a shift that was not suppressed would corrupt every result read back.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_LDP     = 4'd1,
        OP_LDA     = 4'd2,
        OP_LDG     = 4'd3,
        OP_ROUTE_N = 4'd4,
        OP_ROUTE_S = 4'd5,
        OP_ROUTE_E = 4'd6,
        OP_ROUTE_W = 4'd7,
        OP_BOOL    = 4'd8,
        OP_ADD     = 4'd9,
        OP_CLRC    = 4'd10,
        OP_STP     = 4'd11,
        OP_STB     = 4'd12,
        OP_SXCH    = 4'd13
    } pe_op_e;

endpackage

// File: rtl/pe_bitmem.sv
module pe_bitmem #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wd,
    output logic              rd
);
    logic [DEPTH-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (we) bits_q[addr] <= wd;
    end

    assign rd = bits_q[addr];
endmodule

// File: rtl/pe_cell.sv
module pe_cell
    import bsa_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pe_op_e            op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        fn,
    input  logic              masked,
    input  logic              nb_n,
    input  logic              nb_s,
    input  logic              nb_e,
    input  logic              nb_w,
    input  logic              s_shift,
    input  logic              s_west,
    output logic              p_o,
    output logic              s_o
);
    logic p_q, a_q, b_q, c_q, g_q, s_q;
    logic mbit, upd, mem_we, mem_wd;

    // An element takes part unless masking is on and its G is clear.
    assign upd = !masked || g_q;

    pe_bitmem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk  (clk),
        .we   (mem_we),
        .addr (addr),
        .wd   (mem_wd),
        .rd   (mbit)
    );

    always_comb begin
        mem_we = 1'b0;
        mem_wd = 1'b0;
        unique case (op)
            OP_STP:  begin mem_we = upd;  mem_wd = p_q; end
            OP_STB:  begin mem_we = upd;  mem_wd = b_q; end
            OP_SXCH: begin mem_we = 1'b1; mem_wd = s_q; end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= 1'b0;
            a_q <= 1'b0;
            b_q <= 1'b0;
            c_q <= 1'b0;
            g_q <= 1'b0;
        end else begin
            unique case (op)
                OP_LDP:     if (upd) p_q <= mbit;
                OP_LDA:     if (upd) a_q <= mbit;
                OP_LDG:     g_q <= mbit;
                OP_ROUTE_N: if (upd) p_q <= nb_s;
                OP_ROUTE_S: if (upd) p_q <= nb_n;
                OP_ROUTE_E: if (upd) p_q <= nb_w;
                OP_ROUTE_W: if (upd) p_q <= nb_e;
                OP_BOOL:    if (upd) p_q <= fn[{p_q, mbit}];
                OP_ADD: if (upd) begin
                    b_q <= a_q ^ p_q ^ c_q;
                    c_q <= (a_q & p_q) | (a_q & c_q) | (p_q & c_q);
                end
                OP_CLRC:    if (upd) c_q <= 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              s_q <= 1'b0;
        else if (op == OP_SXCH)  s_q <= mbit;
        else if (s_shift)        s_q <= s_west;
    end

    assign p_o = p_q;
    assign s_o = s_q;

    // R6: a masked-off element keeps its working registers
    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (masked && !g_q && op != OP_LDG && op != OP_SXCH)
        |=> (p_q == $past(p_q) && a_q == $past(a_q) && b_q == $past(b_q) && c_q == $past(c_q)));

    // R5: clearing the carry in an active element
    assert_carry_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLRC && upd) |=> (c_q == 1'b0));

    // R9: exchange loads S from the memory bit seen before the edge
    assert_xchg_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SXCH) |=> (s_q == $past(mbit)));
endmodule

// File: rtl/bitserial_array.sv
module bitserial_array
    import bsa_pkg::*;
#(
    parameter int ROWS   = 8,
    parameter int COLS   = 8,
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [3:0]        fn_i,
    input  logic              mask_en_i,
    input  logic              s_shift_i,
    input  logic [ROWS-1:0]   s_in_i,
    output logic [ROWS-1:0]   s_out_o,
    output logic              any_p_o
);
    localparam int NPE = ROWS * COLS;

    pe_op_e          op_e;
    logic [NPE-1:0]  p_flat;
    logic [NPE-1:0]  s_flat;
    logic [ROWS-1:0] s_penult;

    assign op_e = pe_op_e'(op_i);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int IDX = r * COLS + c;
            logic nn, ns, ne, nw, sw;

            if (r == 0)        begin : g_tn assign nn = 1'b0; end
            else               begin : g_in assign nn = p_flat[IDX-COLS]; end
            if (r == ROWS - 1) begin : g_ts assign ns = 1'b0; end
            else               begin : g_is assign ns = p_flat[IDX+COLS]; end
            if (c == 0) begin : g_tw
                assign nw = 1'b0;
                assign sw = s_in_i[r];
            end else begin : g_iw
                assign nw = p_flat[IDX-1];
                assign sw = s_flat[IDX-1];
            end
            if (c == COLS - 1) begin : g_te assign ne = 1'b0; end
            else               begin : g_ie assign ne = p_flat[IDX+1]; end

            pe_cell #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_pe (
                .clk     (clk),
                .rst_n   (rst_n),
                .op      (op_e),
                .addr    (addr_i),
                .fn      (fn_i),
                .masked  (mask_en_i),
                .nb_n    (nn),
                .nb_s    (ns),
                .nb_e    (ne),
                .nb_w    (nw),
                .s_shift (s_shift_i),
                .s_west  (sw),
                .p_o     (p_flat[IDX]),
                .s_o     (s_flat[IDX])
            );
        end
        assign s_out_o[r] = s_flat[r*COLS + COLS - 1];
        if (COLS > 1) begin : g_pen
            assign s_penult[r] = s_flat[r*COLS + COLS - 2];
        end else begin : g_pen1
            assign s_penult[r] = s_in_i[r];
        end
    end

    assign any_p_o = |p_flat;

    // R3: routing south leaves row 0 empty
    assert_edge_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_ROUTE_S && !mask_en_i) |=> (p_flat[COLS-1:0] == '0));

    // R8: a shift step presents the former next-to-last column
    assert_shift_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_shift_i && op_e != OP_SXCH) |=> (s_out_o == $past(s_penult)));

    // R1: idle array reports nothing while held in reset
    always_comb begin
        if (!rst_n) assert_reset_idle_R1: assert (p_flat == '0 && s_flat == '0);
    end
endmodule

// File: tb/tb_bitserial_array.sv
module tb_bitserial_array;
    import bsa_pkg::*;

    localparam int ROWS = 8;
    localparam int COLS = 8;
    localparam int N    = ROWS * COLS;
    localparam int AW   = 6;
    localparam int WB   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      op_i = 4'd0;
    logic [AW-1:0]   addr_i = '0;
    logic [3:0]      fn_i = 4'd0;
    logic            mask_en_i = 1'b0;
    logic            s_shift_i = 1'b0;
    logic [ROWS-1:0] s_in_i = '0;
    logic [ROWS-1:0] s_out_o;
    logic            any_p_o;

    int checks = 0;
    int errors = 0;
    int xw[N], yw[N], ww[N], got[N];

    always #2.5 clk = ~clk;

    bitserial_array #(.ROWS(ROWS), .COLS(COLS), .DEPTH(64), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .addr_i(addr_i), .fn_i(fn_i),
        .mask_en_i(mask_en_i), .s_shift_i(s_shift_i), .s_in_i(s_in_i),
        .s_out_o(s_out_o), .any_p_o(any_p_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input pe_op_e o, input int ad, input logic [3:0] f,
                       input logic m, input logic sh);
        op_i = o; addr_i = AW'(ad); fn_i = f; mask_en_i = m; s_shift_i = sh;
        @(posedge clk); @(negedge clk);
        op_i = OP_NOP; mask_en_i = 1'b0; s_shift_i = 1'b0;
    endtask

    task automatic put_plane(input logic [N-1:0] fl, input int ad, input pe_op_e side_op);
        for (int k = 0; k < COLS; k++) begin
            for (int r = 0; r < ROWS; r++) s_in_i[r] = fl[r*COLS + COLS - 1 - k];
            cyc(side_op, 0, 4'd0, 1'b0, 1'b1);
        end
        cyc(OP_SXCH, ad, 4'd0, 1'b0, 1'b0);
    endtask

    // R9: the shift request is held high during the exchange and must be ignored.
    task automatic get_plane(input int ad, output logic [N-1:0] fl);
        fl = '0;
        cyc(OP_SXCH, ad, 4'd0, 1'b0, 1'b1);
        for (int k = 0; k < COLS; k++) begin
            for (int r = 0; r < ROWS; r++) fl[r*COLS + COLS - 1 - k] = s_out_o[r];
            s_in_i = s_out_o;
            cyc(OP_NOP, 0, 4'd0, 1'b0, 1'b1);
        end
        cyc(OP_SXCH, ad, 4'd0, 1'b0, 1'b0);
    endtask

    task automatic put_words(input int base, input int w[N]);
        logic [N-1:0] fl;
        for (int k = 0; k < WB; k++) begin
            for (int e = 0; e < N; e++) fl[e] = w[e][k];
            put_plane(fl, base + k, OP_NOP);
        end
    endtask

    task automatic get_words(input int base, output int w[N]);
        logic [N-1:0] fl;
        for (int e = 0; e < N; e++) w[e] = 0;
        for (int k = 0; k < WB; k++) begin
            get_plane(base + k, fl);
            for (int e = 0; e < N; e++) w[e] = w[e] | (int'(fl[e]) << k);
        end
    endtask

    task automatic add_words(input int ba, input int bb, input int bd);
        cyc(OP_CLRC, 0, 4'd0, 1'b0, 1'b0);
        for (int k = 0; k < WB; k++) begin
            cyc(OP_LDA, ba + k, 4'd0, 1'b0, 1'b0);
            cyc(OP_LDP, bb + k, 4'd0, 1'b0, 1'b0);
            cyc(OP_ADD, 0, 4'd0, 1'b0, 1'b0);
            cyc(OP_STB, bd + k, 4'd0, 1'b0, 1'b0);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [N-1:0] fl, src, zero_pl, one_pl;
        logic [3:0]   fns[3];
        pe_op_e       dirs[4];
        int           exp_b;

        for (int e = 0; e < N; e++) begin
            xw[e] = ((e / COLS) * 37 + (e % COLS) * 11 + 5) & 255;
            yw[e] = ((e / COLS) * (e % COLS) * 7 + (e / COLS) * 3 + 200) & 255;
            ww[e] = 255 - xw[e];
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 any_p in reset", int'(any_p_o), 0);
        chk("R1 s_out in reset", int'(s_out_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 any_p after reset", int'(any_p_o), 0);

        // R7 R9: plane transfer and readback
        put_words(0, xw);
        put_words(8, yw);
        put_words(32, ww);
        get_words(0, got);
        for (int e = 0; e < N; e++) chk("R9 readback x", got[e], xw[e]);

        // R5: bit-serial additions
        add_words(0, 8, 16);
        get_words(16, got);
        for (int e = 0; e < N; e++) chk("R5 sum x+y", got[e], (xw[e] + yw[e]) & 255);
        add_words(8, 32, 24);
        get_words(24, got);
        for (int e = 0; e < N; e++) chk("R5 sum y+w", got[e], (yw[e] + ww[e]) & 255);

        // R4: boolean truth tables, index 2*P+M
        fns[0] = 4'b1000; fns[1] = 4'b0110; fns[2] = 4'b0011;
        for (int f = 0; f < 3; f++) begin
            cyc(OP_LDP, 3, 4'd0, 1'b0, 1'b0);
            cyc(OP_BOOL, 11, fns[f], 1'b0, 1'b0);
            cyc(OP_STP, 52, 4'd0, 1'b0, 1'b0);
            get_plane(52, fl);
            for (int e = 0; e < N; e++) begin
                exp_b = int'(fns[f][{xw[e][3], yw[e][3]}]);
                chk("R4 bool", int'(fl[e]), exp_b);
            end
        end

        // R3: routing in four directions with zero fill
        dirs[0] = OP_ROUTE_N; dirs[1] = OP_ROUTE_S; dirs[2] = OP_ROUTE_E; dirs[3] = OP_ROUTE_W;
        for (int e = 0; e < N; e++) src[e] = xw[e][2];
        for (int d = 0; d < 4; d++) begin
            cyc(OP_LDP, 2, 4'd0, 1'b0, 1'b0);
            cyc(dirs[d], 0, 4'd0, 1'b0, 1'b0);
            cyc(OP_STP, 50, 4'd0, 1'b0, 1'b0);
            get_plane(50, fl);
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    exp_b = 0;
                    if (d == 0 && r < ROWS - 1) exp_b = int'(src[(r+1)*COLS + c]);
                    if (d == 1 && r > 0)        exp_b = int'(src[(r-1)*COLS + c]);
                    if (d == 2 && c > 0)        exp_b = int'(src[r*COLS + c - 1]);
                    if (d == 3 && c < COLS - 1) exp_b = int'(src[r*COLS + c + 1]);
                    chk("R3 route", int'(fl[r*COLS + c]), exp_b);
                end
            end
        end

        // R10: array-wide OR of P
        zero_pl = '0;
        one_pl = '0; one_pl[37] = 1'b1;
        put_plane(zero_pl, 60, OP_NOP);
        put_plane(one_pl, 61, OP_NOP);
        cyc(OP_LDP, 60, 4'd0, 1'b0, 1'b0);
        chk("R10 any_p all zero", int'(any_p_o), 0);
        cyc(OP_LDP, 61, 4'd0, 1'b0, 1'b0);
        chk("R10 any_p single bit", int'(any_p_o), 1);

        // R8: shift-in overlapped with eight east routes
        cyc(OP_LDP, 2, 4'd0, 1'b0, 1'b0);
        chk("R8 P loaded before overlap", int'(any_p_o), 1);
        for (int e = 0; e < N; e++) fl[e] = yw[e][5];
        src = fl;
        put_plane(src, 54, OP_ROUTE_E);
        chk("R8 P drained by routes", int'(any_p_o), 0);
        get_plane(54, fl);
        for (int e = 0; e < N; e++) chk("R8 plane shifted in", int'(fl[e]), int'(src[e]));

        // R6: masked clear of negative words using the sign plane
        cyc(OP_LDG, 7, 4'd0, 1'b0, 1'b0);
        cyc(OP_BOOL, 0, 4'b0000, 1'b1, 1'b0);
        for (int k = 0; k < WB; k++) cyc(OP_STP, k, 4'd0, 1'b1, 1'b0);
        for (int k = 0; k < WB; k++) begin
            get_plane(k, fl);
            for (int e = 0; e < N; e++)
                chk("R6 masked clear plane", int'(fl[e]), (xw[e] >= 128) ? 0 : int'(xw[e][k]));
        end

        // R2: unused codes behave as NOP
        cyc(OP_LDP, 61, 4'd0, 1'b0, 1'b0);
        op_i = 4'd15; @(posedge clk); @(negedge clk); op_i = 4'd0;
        chk("R2 code 15 is NOP", int'(any_p_o), 1);

        finish_run();
    end
endmodule